// File: doc/BRIEF.md
# Differential PSK Symbol Modulator

This block turns a serial bit stream into differentially encoded phase symbols for a direct-sequence spread-spectrum transmitter. A symbol carries one bit (binary differential mode, 1 Mbps) or two bits (quaternary differential mode, 2 Mbps). The block spreads each symbol over an 11-chip Barker code and emits one I/Q sign pair per clock while a burst is active, which gives 11 Mchip/s when the clock runs at the chip rate.

The framer marks every bit with the packet segment it belongs to: sync field, header or payload. The sync field always uses one bit per symbol. The header and the payload each take their width from a configuration input. The block selects the width for each symbol when that symbol's first bit is accepted, so a change of rate takes effect exactly on a symbol boundary. The accumulated phase reference carries across every rate change. Only the start-of-packet strobe and reset clear it. While the 11 chips of a symbol are being emitted, the bit input is not ready. The framer therefore sees the block's ready signal fall and rise once per symbol.

Top module: `dpsk_chip_mod`

## Requirements
- R1: After reset, chip_valid is 0, bit_ready is 1 and the phase reference is 0. A one-bit symbol carrying 0 then produces the phase-0 chip pattern.
- R2: In one-bit mode, a bit value of 0 leaves the phase unchanged and a bit value of 1 advances it by two quarter turns.
- R3: Segment code 0 (sync field) always forms one-bit symbols, whatever hdr_dq and pay_dq are set to.
- R4: Segment code 1 (header) uses two bits per symbol when hdr_dq is 1 and one bit otherwise. Segment codes 2 and 3 (payload) do the same under pay_dq.
- R5: In two-bit mode, the earlier bit b0 and the later bit b1 advance the phase by a number of quarter turns: b0b1 = 00 gives 0, 01 gives 1, 11 gives 2 and 10 gives 3.
- R6: The symbol width is set when the symbol's first bit is accepted. A change of sym_seg, hdr_dq or pay_dq before the second bit does not alter that symbol.
- R7: The phase reference is kept across changes of symbol width and segment, and changes only when a symbol completes, on sop, or on reset.
- R8: A completed symbol with phase index p produces exactly 11 consecutive cycles of chip_valid. For chip k, chip_i = (Ipos == B[k]) and chip_q = (Qpos == B[k]), where B = 1,0,1,1,0,1,1,1,0,0,0 for k = 0..10, Ipos is 1 for p = 0 or 3, and Qpos is 1 for p = 0 or 1 (a chip value of 1 means +1).
- R9: bit_ready is 0 while chips are emitted, and bit_valid in that time has no effect.
- R10: sop sets the phase reference to 0, discards a half-received two-bit symbol and ends any chip burst in progress. A bit accepted in the same cycle as sop belongs to the new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop | input | 1 | Start-of-packet strobe, one cycle |
| bit_valid | input | 1 | Input bit is offered |
| bit_data | input | 1 | Input bit value |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| sym_seg | input | 2 | Segment of the offered bit: 0 sync, 1 header, 2/3 payload |
| hdr_dq | input | 1 | Header uses two bits per symbol |
| pay_dq | input | 1 | Payload uses two bits per symbol |
| chip_valid | output | 1 | A chip is present on chip_i/chip_q |
| chip_i | output | 1 | In-phase chip sign, 1 means +1 |
| chip_q | output | 1 | Quadrature chip sign, 1 means +1 |

## Verification
A wrong phase reference or wrong symbol width has no effect on the control signals. It appears as a rotated chip pattern, and it does so on the first chip of the next burst, one cycle after the completing bit is accepted. A bad chip counter shows up within 11 cycles as a burst of the wrong length or a ready signal that rises too early. The bench follows the phase independently through rate switches, so an error carried over from one symbol is caught in the symbol that follows it.

// File: rtl/dpsk_chip_mod.sv
module dpsk_chip_mod #(
  parameter int CHIPS = 11,
  parameter logic [CHIPS-1:0] SPREAD_CODE = 11'b00011101101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sop,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic       bit_ready,
  input  logic [1:0] sym_seg,
  input  logic       hdr_dq,
  input  logic       pay_dq,
  output logic       chip_valid,
  output logic       chip_i,
  output logic       chip_q
);
  localparam int CW = (CHIPS > 1) ? $clog2(CHIPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CHIPS - 1);

  logic          spreading, half, held_bit, sym_dq;
  logic [1:0]    phase;
  logic [CW-1:0] cidx;

  logic       dq_now, h, mode, take, done;
  logic [1:0] inc, base;

  assign dq_now = (sym_seg == 2'd0) ? 1'b0 : (sym_seg == 2'd1) ? hdr_dq : pay_dq;
  assign bit_ready = ~spreading;
  assign take = bit_valid & bit_ready;
  assign h    = half & ~sop;
  assign mode = h ? sym_dq : dq_now;
  assign done = take & (~mode | h);
  assign inc  = h ? {held_bit, held_bit ^ bit_data} : {bit_data, 1'b0};
  assign base = sop ? 2'd0 : phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spreading <= 1'b0;
      half      <= 1'b0;
      held_bit  <= 1'b0;
      sym_dq    <= 1'b0;
      phase     <= 2'd0;
      cidx      <= '0;
    end else begin
      if (spreading) begin
        if (cidx == LAST) begin
          spreading <= 1'b0;
          cidx      <= '0;
        end else begin
          cidx <= cidx + 1'b1;
        end
      end
      if (sop) begin
        phase     <= 2'd0;
        half      <= 1'b0;
        spreading <= 1'b0;
        cidx      <= '0;
      end
      if (take) begin
        if (done) begin
          phase     <= base + inc;
          half      <= 1'b0;
          spreading <= 1'b1;
          cidx      <= '0;
        end else begin
          half     <= 1'b1;
          held_bit <= bit_data;
          sym_dq   <= 1'b1;
        end
      end
    end
  end

  logic i_pos, q_pos, code;
  assign i_pos = (phase == 2'd0) | (phase == 2'd3);
  assign q_pos = ~phase[1];
  assign code  = SPREAD_CODE[cidx];

  assign chip_valid = spreading;
  assign chip_i = spreading & (i_pos == code);
  assign chip_q = spreading & (q_pos == code);

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) chip_valid |-> !bit_ready); // R9
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n) (chip_valid && cidx == LAST) |=> !chip_valid); // R8
  AST_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!sop && !(bit_valid && bit_ready)) |=> $stable(phase)); // R7
  AST_SOP_RESET: assert property (@(posedge clk) disable iff (!rst_n) (sop && !bit_valid) |=> (phase == 2'd0 && !chip_valid && !half)); // R10
  AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (bit_valid && bit_ready && !half && sym_seg == 2'd0) |=> chip_valid); // R3
  AST_BURST_PHASE: assert property (@(posedge clk) disable iff (!rst_n) (chip_valid && $past(chip_valid) && !$past(sop)) |-> $stable(phase)); // R8
endmodule

// File: tb/dpsk_chip_mod_tb.sv
`timescale 1ns/1ps
module dpsk_chip_mod_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sop = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic [1:0] sym_seg = 2'd0;
  logic hdr_dq = 1'b0, pay_dq = 1'b0;
  logic bit_ready, chip_valid, chip_i, chip_q;

  int n_chk = 0, n_bad = 0;
  int ref_ph = 0;
  localparam logic [10:0] BK = 11'b00011101101;

  dpsk_chip_mod dut_i (.clk(clk), .rst_n(rst_n), .sop(sop), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .sym_seg(sym_seg), .hdr_dq(hdr_dq),
    .pay_dq(pay_dq), .chip_valid(chip_valid), .chip_i(chip_i), .chip_q(chip_q));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int gray_steps(input bit b0, input bit b1);
    case ({b0, b1})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check_burst(input string req, input bit jam);
    bit ip, qp, ei, eq;
    ip = (ref_ph == 0) || (ref_ph == 3);
    qp = (ref_ph < 2);
    for (int k = 0; k < 11; k++) begin
      ei = (ip == BK[k]);
      eq = (qp == BK[k]);
      chk(chip_valid === 1'b1, {req, " R8 valid"}, chip_valid, 1);
      chk({chip_i, chip_q} === {ei, eq}, {req, " R8 chip"}, {chip_i, chip_q}, {ei, eq});
      if (jam) begin
        chk(bit_ready === 1'b0, "R9 ready low", bit_ready, 0);
        bit_valid = (k < 10);
        bit_data  = 1'b1;
      end
      @(negedge clk);
    end
    chk(chip_valid === 1'b0, {req, " R8 burst length"}, chip_valid, 0);
    chk(bit_ready === 1'b1, {req, " R9 ready back"}, bit_ready, 1);
  endtask

  task automatic send_sym(input logic [1:0] seg, input int nb, input bit b0, input bit b1,
                          input string req, input bit jam);
    sym_seg = seg; bit_valid = 1'b1; bit_data = b0;
    @(negedge clk);
    if (nb == 2) begin
      bit_data = b1;
      @(negedge clk);
    end
    bit_valid = 1'b0;
    if (nb == 2) ref_ph = (ref_ph + gray_steps(b0, b1)) % 4;
    else ref_ph = (ref_ph + (b0 ? 2 : 0)) % 4;
    check_burst(req, jam);
  endtask

  task automatic t_reset;
    chk(chip_valid === 1'b0, "R1 chip_valid", chip_valid, 0);
    chk(bit_ready === 1'b1, "R1 bit_ready", bit_ready, 1);
    send_sym(2'd0, 1, 1'b0, 1'b0, "R1 phase zero", 1'b0);
  endtask

  task automatic t_sync;
    hdr_dq = 1'b1; pay_dq = 1'b1;
    send_sym(2'd0, 1, 1'b1, 1'b0, "R2 R3 bit1", 1'b0);
    send_sym(2'd0, 1, 1'b0, 1'b0, "R2 R3 bit0", 1'b0);
    send_sym(2'd0, 1, 1'b1, 1'b0, "R2 R3 bit1 again", 1'b0);
  endtask

  task automatic t_header;
    hdr_dq = 1'b1;
    send_sym(2'd1, 2, 1'b0, 1'b1, "R4 R5 R7 dibit01", 1'b0);
    send_sym(2'd1, 2, 1'b1, 1'b1, "R5 dibit11", 1'b0);
    send_sym(2'd1, 2, 1'b1, 1'b0, "R5 dibit10", 1'b0);
    send_sym(2'd1, 2, 1'b0, 1'b0, "R5 dibit00", 1'b0);
    hdr_dq = 1'b0;
    send_sym(2'd1, 1, 1'b1, 1'b0, "R4 header one-bit", 1'b0);
  endtask

  task automatic t_payload;
    pay_dq = 1'b1;
    send_sym(2'd2, 2, 1'b0, 1'b1, "R4 R7 payload dibit", 1'b0);
    pay_dq = 1'b0;
    send_sym(2'd3, 1, 1'b1, 1'b0, "R4 payload one-bit", 1'b0);
    send_sym(2'd0, 1, 1'b0, 1'b0, "R7 back to sync", 1'b0);
  endtask

  task automatic t_midswitch;
    hdr_dq = 1'b1;
    sym_seg = 2'd1; bit_valid = 1'b1; bit_data = 1'b1;
    @(negedge clk);
    sym_seg = 2'd0; hdr_dq = 1'b0; bit_data = 1'b0;
    chk(chip_valid === 1'b0, "R6 no burst after first bit", chip_valid, 0);
    @(negedge clk);
    bit_valid = 1'b0;
    ref_ph = (ref_ph + gray_steps(1'b1, 1'b0)) % 4;
    check_burst("R6 width fixed at first bit", 1'b0);
  endtask

  task automatic t_ignore;
    send_sym(2'd0, 1, 1'b0, 1'b0, "R9 jammed burst", 1'b1);
    send_sym(2'd0, 1, 1'b0, 1'b0, "R9 jam had no effect", 1'b0);
  endtask

  task automatic t_sop;
    send_sym(2'd0, 1, 1'b1, 1'b0, "R10 setup", 1'b0);
    hdr_dq = 1'b1;
    sym_seg = 2'd1; bit_valid = 1'b1; bit_data = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0; sop = 1'b1;
    @(negedge clk);
    sop = 1'b0; ref_ph = 0;
    chk(chip_valid === 1'b0, "R10 no burst", chip_valid, 0);
    send_sym(2'd0, 1, 1'b0, 1'b0, "R10 half dropped phase cleared", 1'b0);
    sym_seg = 2'd0; bit_valid = 1'b1; bit_data = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sop = 1'b1;
    @(negedge clk);
    sop = 1'b0; ref_ph = 0;
    chk(chip_valid === 1'b0, "R10 burst aborted", chip_valid, 0);
    chk(bit_ready === 1'b1, "R10 ready after abort", bit_ready, 1);
    sop = 1'b1; sym_seg = 2'd0; bit_valid = 1'b1; bit_data = 1'b1;
    ref_ph = 0;
    @(negedge clk);
    sop = 1'b0; bit_valid = 1'b0;
    ref_ph = 2;
    check_burst("R10 bit with sop", 1'b0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync();
    t_header();
    t_payload();
    t_midswitch();
    t_ignore();
    t_sop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule